// File: doc/BRIEF.md
# Filtered Branch Record Ring

This block keeps a short history of taken control-flow transfers. Each retired branch event carries a source address, a target address, a privilege flag, a kind code and three status flags. An event that passes the filter is written as a (source word, target) pair into a circular buffer of `DEPTH` slots, where `DEPTH` is a power of two. A pointer always names the slot that holds the newest record. Older records are found by stepping the pointer backwards, modulo the depth.

A ten-bit select register decides what is captured. Its lower nine bits are suppress controls: a set bit blocks one privilege class or one branch kind. The top bit turns the ring into a call stack. In that mode calls push a record and returns pop one. A control register holds the enable bit and the freeze-on-interrupt bit. When freezing is armed, a pulse on the interrupt input latches a frozen state, and capture stays stopped until software clears that state through the register port.

The register port is a simple request/write-enable interface. Reads return data one cycle after the request. Through it, software reaches every source slot, every target slot, the pointer, the select bits and the control bits, and it can issue a clear command that wipes the whole buffer.

Top module: `branch_trail`

## Requirements
- R1: After reset the control register, the select register and the pointer read 0, and every source and target slot reads 0.
- R2: With recording enabled, and outside call-stack mode, every accepted event advances the pointer by one modulo DEPTH. It then writes the new slot: the target is stored unchanged, and the source word is stored as {mispredict, in-transaction, abort, source[60:0]} (bits 63, 62 and 61 hold the flags). The record k events back sits at slot (pointer - k) & (DEPTH-1).
- R3: Select bit 0 blocks events whose privilege flag `br_ring0` is 1. Select bit 1 blocks events whose flag is 0.
- R4: Kind codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch, 7 other. For kinds 0 to 6, select bit (kind+2) blocks that kind. Kind 7 is filtered by privilege only.
- R5: Only select bits 9:0 are stored. Writes to higher bits have no effect, and those bits read as 0.
- R6: When select bit 9 is set (call-stack mode), accepted calls (kinds 1 and 2) push as in R2. An accepted return (kind 3) zeroes both halves of the pointer's slot and decrements the pointer. All other kinds are not recorded.
- R7: Control bit 0 enables recording. While it is 0, events change neither the pointer nor the buffer.
- R8: Control bit 1 arms freezing. An interrupt pulse while bits 0 and 1 are both set makes control bit 2 (frozen) read 1 from the next cycle on. An event in the interrupt's own cycle is still recorded. Later events are ignored until a control write with bit 2 = 0. An interrupt while freezing is not armed has no effect.
- R9: A write to address 0x03 zeroes every source and target slot and leaves the pointer unchanged.
- R10: Register map: 0x00 control, 0x01 select, 0x02 pointer, 0x03 clear, 0x40+i source slot i, 0x80+i target slot i. Read data is valid one cycle after the request. A write is visible to a read requested in the following cycle.
- R11: An event that arrives in the same cycle as a register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Retired taken-branch event strobe |
| br_from | input | 64 | Source address |
| br_to | input | 64 | Target address |
| br_ring0 | input | 1 | 1 when the event runs at the most privileged level |
| br_kind | input | 3 | Branch kind code (see R4) |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch was inside a transaction |
| br_abort | input | 1 | Branch was a transaction abort |
| freeze_irq | input | 1 | Performance-interrupt pulse |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register address (see R10) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the request |

## Verification
Two pairs of functions can land on the same edge. The first is a branch event meeting the freeze interrupt. The bench raises both strobes in one cycle and then expects the pointer to have advanced, with control bit 2 set from the next cycle. The second is a branch event meeting a register write. The bench drives a select write beside a valid event and expects the pointer and the buffer to stay unchanged. The checker also requires that no push or pop ever coincides with a write or with the frozen state.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [2:0] {
    K_COND  = 3'd0,
    K_RCALL = 3'd1,
    K_ICALL = 3'd2,
    K_RET   = 3'd3,
    K_IJMP  = 3'd4,
    K_RJMP  = 3'd5,
    K_FAR   = 3'd6,
    K_OTHER = 3'd7
  } br_kind_e;

  localparam int SEL_W      = 10;
  localparam int SEL_RING0  = 0;
  localparam int SEL_RINGN  = 1;
  localparam int SEL_KIND0  = 2;
  localparam int SEL_STACK  = 9;

  localparam int CTL_EN     = 0;
  localparam int CTL_FRZEN  = 1;
  localparam int CTL_FROZEN = 2;

  localparam logic [7:0] RA_CTRL = 8'h00;
  localparam logic [7:0] RA_SEL  = 8'h01;
  localparam logic [7:0] RA_TOS  = 8'h02;
  localparam logic [7:0] RA_CLR  = 8'h03;

  localparam logic [1:0] RG_MISC = 2'b00;
  localparam logic [1:0] RG_FROM = 2'b01;
  localparam logic [1:0] RG_TO   = 2'b10;

  // True when the select bits veto this event.
  function automatic logic is_suppressed(input logic [SEL_W-1:0] sel,
                                         input logic ring0,
                                         input br_kind_e kind);
    logic s;
    s = ring0 ? sel[SEL_RING0] : sel[SEL_RINGN];
    if (kind != K_OTHER)
      s = s | sel[SEL_KIND0 + int'(kind)];
    return s;
  endfunction

  // Source word layout: flags in the top three bits, address below.
  function automatic logic [63:0] pack_src(input logic [60:0] addr,
                                           input logic mis,
                                           input logic intx,
                                           input logic abt);
    return {mis, intx, abt, addr};
  endfunction

  function automatic logic is_call(input br_kind_e kind);
    return (kind == K_RCALL) || (kind == K_ICALL);
  endfunction

endpackage

// File: rtl/bt_filter.sv
module bt_filter
  import bt_pkg::*;
(
  input  logic             br_valid,
  input  logic             br_ring0,
  input  br_kind_e         br_kind,
  input  logic [SEL_W-1:0] sel,
  input  logic             enable,
  input  logic             frozen,
  input  logic             blocked,
  output logic             cap_push,
  output logic             cap_pop
);

  logic live;
  logic stack_mode;

  assign stack_mode = sel[SEL_STACK];
  assign live = br_valid && enable && !frozen && !blocked &&
                !is_suppressed(sel, br_ring0, br_kind);

  assign cap_push = live && (!stack_mode || is_call(br_kind));
  assign cap_pop  = live && stack_mode && (br_kind == K_RET);

endmodule

// File: rtl/bt_ptr.sv
module bt_ptr #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [IDX_W-1:0] ld_val,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] tos_q,
  output logic [IDX_W-1:0] tos_up
);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p,
                                            input logic up);
    return up ? p + IDX_W'(1) : p - IDX_W'(1);
  endfunction

  assign tos_up = step(tos_q, 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tos_q <= '0;
    else if (ld)   tos_q <= ld_val;
    else if (push) tos_q <= tos_up;
    else if (pop)  tos_q <= step(tos_q, 1'b0);
  end

endmodule

// File: rtl/bt_store.sv
module bt_store #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we_from,
  input  logic             we_to,
  input  logic [IDX_W-1:0] widx,
  input  logic [63:0]      wfrom,
  input  logic [63:0]      wto,
  input  logic [IDX_W-1:0] ridx,
  output logic [63:0]      rfrom,
  output logic [63:0]      rto
);

  logic [63:0] from_q [DEPTH];
  logic [63:0] to_q   [DEPTH];
  logic [DEPTH-1:0] hit_from;
  logic [DEPTH-1:0] hit_to;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign hit_from[i] = we_from && (widx == IDX_W'(i));
    assign hit_to[i]   = we_to   && (widx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        from_q[i] <= '0;
        to_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (clr) begin
          from_q[i] <= '0;
          to_q[i]   <= '0;
        end else begin
          if (hit_from[i]) from_q[i] <= wfrom;
          if (hit_to[i])   to_q[i]   <= wto;
        end
      end
    end
  end

  assign rfrom = from_q[ridx];
  assign rto   = to_q[ridx];

endmodule

// File: rtl/branch_trail.sv
module branch_trail
  import bt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        br_valid,
  input  logic [63:0] br_from,
  input  logic [63:0] br_to,
  input  logic        br_ring0,
  input  logic [2:0]  br_kind,
  input  logic        br_mispred,
  input  logic        br_in_tx,
  input  logic        br_abort,
  input  logic        freeze_irq,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata
);

  localparam int IDX_W = $clog2(DEPTH);

  // Control state
  logic             en_q, frz_en_q, frozen_q;
  logic [SEL_W-1:0] sel_q;

  // Register decode
  logic             wr, rd;
  logic [1:0]       grp;
  logic [IDX_W-1:0] off;
  logic             wr_ctrl, wr_sel, ptr_ld, clr_all, wr_from, wr_to;

  assign wr      = reg_req && reg_we;
  assign rd      = reg_req && !reg_we;
  assign grp     = reg_addr[7:6];
  assign off     = reg_addr[IDX_W-1:0];
  assign wr_ctrl = wr && (reg_addr == RA_CTRL);
  assign wr_sel  = wr && (reg_addr == RA_SEL);
  assign ptr_ld  = wr && (reg_addr == RA_TOS);
  assign clr_all = wr && (reg_addr == RA_CLR);
  assign wr_from = wr && (grp == RG_FROM);
  assign wr_to   = wr && (grp == RG_TO);

  // Internal events brought out for the checker
  logic             cap_push, cap_pop, frz_evt;
  logic [IDX_W-1:0] tos_q, tos_up;

  assign frz_evt = freeze_irq && en_q && frz_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      frz_en_q <= 1'b0;
      frozen_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q     <= reg_wdata[CTL_EN];
        frz_en_q <= reg_wdata[CTL_FRZEN];
        frozen_q <= reg_wdata[CTL_FROZEN];
      end else if (frz_evt) begin
        frozen_q <= 1'b1;
      end
      if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
    end
  end

  bt_filter u_filter (
    .br_valid (br_valid),
    .br_ring0 (br_ring0),
    .br_kind  (br_kind_e'(br_kind)),
    .sel      (sel_q),
    .enable   (en_q),
    .frozen   (frozen_q),
    .blocked  (wr),
    .cap_push (cap_push),
    .cap_pop  (cap_pop)
  );

  bt_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ptr_ld),
    .ld_val (reg_wdata[IDX_W-1:0]),
    .push   (cap_push),
    .pop    (cap_pop),
    .tos_q  (tos_q),
    .tos_up (tos_up)
  );

  // Store write port: register path or capture path (never both)
  logic             st_we_from, st_we_to;
  logic [IDX_W-1:0] st_widx;
  logic [63:0]      st_wfrom, st_wto;
  logic [63:0]      st_rfrom, st_rto;

  always_comb begin
    st_we_from = 1'b0;
    st_we_to   = 1'b0;
    st_widx    = off;
    st_wfrom   = reg_wdata;
    st_wto     = reg_wdata;
    if (wr) begin
      st_we_from = wr_from;
      st_we_to   = wr_to;
    end else if (cap_push) begin
      st_we_from = 1'b1;
      st_we_to   = 1'b1;
      st_widx    = tos_up;
      st_wfrom   = pack_src(br_from[60:0], br_mispred, br_in_tx, br_abort);
      st_wto     = br_to;
    end else if (cap_pop) begin
      st_we_from = 1'b1;
      st_we_to   = 1'b1;
      st_widx    = tos_q;
      st_wfrom   = '0;
      st_wto     = '0;
    end
  end

  bt_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_all),
    .we_from (st_we_from),
    .we_to   (st_we_to),
    .widx    (st_widx),
    .wfrom   (st_wfrom),
    .wto     (st_wto),
    .ridx    (off),
    .rfrom   (st_rfrom),
    .rto     (st_rto)
  );

  // Registered read data
  logic [63:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (grp)
      RG_FROM: rd_mux = st_rfrom;
      RG_TO:   rd_mux = st_rto;
      RG_MISC: begin
        if (reg_addr == RA_CTRL) rd_mux = 64'({frozen_q, frz_en_q, en_q});
        else if (reg_addr == RA_SEL) rd_mux = 64'(sel_q);
        else if (reg_addr == RA_TOS) rd_mux = 64'(tos_q);
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  reg_rdata <= '0;
    else if (rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/bt_chk.sv
module bt_chk #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_push,
  input logic             cap_pop,
  input logic             ptr_ld,
  input logic             frozen_q,
  input logic [IDX_W-1:0] tos_q,
  input logic             reg_req,
  input logic             reg_we,
  input logic [7:0]       reg_addr,
  input logic [63:0]      reg_rdata
);

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_push |=> tos_q == IDX_W'($past(tos_q) + IDX_W'(1)));

  // R6
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pop |=> tos_q == IDX_W'($past(tos_q) - IDX_W'(1)));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_push && !cap_pop && !ptr_ld) |=> $stable(tos_q));

  // R8
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> (!cap_push && !cap_pop));

  // R11
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> $onehot0({cap_push, cap_pop, ptr_ld}) && !cap_push && !cap_pop);

  // R10
  rd_tos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we && reg_addr == 8'h02) |=> reg_rdata == 64'($past(tos_q)));

endmodule

bind branch_trail bt_chk #(.DEPTH(DEPTH), .IDX_W($clog2(DEPTH))) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_push  (cap_push),
  .cap_pop   (cap_pop),
  .ptr_ld    (ptr_ld),
  .frozen_q  (frozen_q),
  .tos_q     (tos_q),
  .reg_req   (reg_req),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata)
);

// File: tb/test_branch_trail.sv
`timescale 1ns/1ps
module test_branch_trail;

  localparam int DEPTH = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_SEL = 8'h01, A_TOS = 8'h02, A_CLR = 8'h03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 0, br_ring0 = 0, br_mispred = 0, br_in_tx = 0, br_abort = 0;
  logic [63:0] br_from = '0, br_to = '0;
  logic [2:0]  br_kind = '0;
  logic        freeze_irq = 0;
  logic        reg_req = 0, reg_we = 0;
  logic [7:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  branch_trail #(.DEPTH(DEPTH)) i_branch_trail (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
    .br_ring0(br_ring0), .br_kind(br_kind), .br_mispred(br_mispred), .br_in_tx(br_in_tx),
    .br_abort(br_abort), .freeze_irq(freeze_irq), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [63:0] exp_src(input logic [63:0] a, input logic m, x, ab);
    logic [63:0] w;
    w = a & 64'h1FFF_FFFF_FFFF_FFFF;
    w[63] = m; w[62] = x; w[61] = ab;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_req = 0;
    d = reg_rdata;
  endtask

  task automatic br(input logic [63:0] f, input logic [63:0] t, input logic r0,
                    input logic [2:0] k, input logic m, input logic x, input logic ab);
    @(negedge clk);
    br_valid = 1; br_from = f; br_to = t; br_ring0 = r0; br_kind = k;
    br_mispred = m; br_in_tx = x; br_abort = ab;
    @(negedge clk);
    br_valid = 0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    logic [63:0] acc;
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_SEL, d);  chk("R1 sel", d, 0);
    rd(A_TOS, d);  chk("R1 tos", d, 0);
    acc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h40 + 8'(i), d); acc |= d;
      rd(8'h80 + 8'(i), d); acc |= d;
    end
    chk("R1 slots zero", acc, 0);
  endtask

  task automatic t_capture;
    logic [63:0] d;
    wr(A_CTRL, 1); wr(A_SEL, 0); wr(A_TOS, 0);
    br(64'h0000_7FFF_0000_1000, 64'h0000_7FFF_0000_2000, 0, 3'd0, 0, 0, 0);
    br(64'hFFFF_FFFF_8100_0000, 64'hFFFF_FFFF_8100_0040, 1, 3'd5, 0, 0, 0);
    br(64'h0000_7FFF_0000_3000, 64'h0000_7FFF_0000_4000, 0, 3'd7, 1, 0, 1);
    rd(A_TOS, d); chk("R2 tos after three", d, 3);
    rd(8'h43, d); chk("R2 newest src flags", d, exp_src(64'h0000_7FFF_0000_3000, 1, 0, 1));
    rd(8'h83, d); chk("R2 newest dst", d, 64'h0000_7FFF_0000_4000);
    rd(8'h42, d); chk("R2 src top bits replaced", d, 64'h1FFF_FFFF_8100_0000);
    rd(8'h41, d); chk("R2 two back", d, exp_src(64'h0000_7FFF_0000_1000, 0, 0, 0));
    wr(A_TOS, 15);
    rd(A_TOS, d); chk("R10 tos write visible", d, 15);
    br(64'h0000_0000_0000_5000, 64'h0000_0000_0000_6000, 0, 3'd4, 0, 1, 0);
    rd(A_TOS, d); chk("R2 wrap", d, 0);
    rd(8'h40, d); chk("R2 wrap slot", d, exp_src(64'h5000, 0, 1, 0));
  endtask

  task automatic t_priv;
    logic [63:0] d;
    wr(A_TOS, 0); wr(A_SEL, 64'h1);
    br(64'h100, 64'h200, 1, 3'd0, 0, 0, 0);
    rd(A_TOS, d); chk("R3 ring0 blocked", d, 0);
    br(64'h100, 64'h200, 0, 3'd0, 0, 0, 0);
    rd(A_TOS, d); chk("R3 user kept", d, 1);
    wr(A_SEL, 64'h2);
    br(64'h100, 64'h200, 0, 3'd7, 0, 0, 0);
    rd(A_TOS, d); chk("R3 user blocked", d, 1);
    br(64'h100, 64'h200, 1, 3'd7, 0, 0, 0);
    rd(A_TOS, d); chk("R3 ring0 kept", d, 2);
  endtask

  task automatic t_kind;
    logic [63:0] d;
    logic [63:0] t0;
    for (int k = 0; k < 7; k++) begin
      wr(A_SEL, 64'(1) << (k + 2));
      rd(A_TOS, t0);
      br(64'h1000 + 64'(k), 64'h2000, 0, 3'(k), 0, 0, 0);
      rd(A_TOS, d); chk($sformatf("R4 kind %0d blocked", k), d, t0);
      br(64'h3000 + 64'(k), 64'h4000, 0, 3'((k + 1) % 7), 0, 0, 0);
      rd(A_TOS, d); chk($sformatf("R4 kind %0d passes", (k + 1) % 7), d, (t0 + 1) & 15);
    end
  endtask

  task automatic t_selmask;
    logic [63:0] d;
    wr(A_SEL, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_SEL, d); chk("R5 sel width", d, 64'h3FF);
    wr(A_SEL, 0);
  endtask

  task automatic t_callstack;
    logic [63:0] d;
    wr(A_CLR, 0); wr(A_TOS, 0); wr(A_SEL, 64'h200);
    br(64'hA00, 64'hA80, 0, 3'd1, 0, 0, 0);
    br(64'hB00, 64'hB80, 0, 3'd2, 0, 0, 0);
    rd(A_TOS, d); chk("R6 two pushes", d, 2);
    br(64'hC00, 64'hC80, 0, 3'd0, 0, 0, 0);
    rd(A_TOS, d); chk("R6 cond ignored", d, 2);
    br(64'hD00, 64'hD80, 0, 3'd3, 0, 0, 0);
    rd(A_TOS, d); chk("R6 pop", d, 1);
    rd(8'h42, d); chk("R6 vacated src", d, 0);
    rd(8'h82, d); chk("R6 vacated dst", d, 0);
    rd(8'h41, d); chk("R6 remaining", d, 64'hA00);
    wr(A_SEL, 0);
  endtask

  task automatic t_enable;
    logic [63:0] d;
    logic [63:0] t0;
    rd(A_TOS, t0);
    wr(A_CTRL, 0);
    br(64'h700, 64'h800, 0, 3'd0, 0, 0, 0);
    rd(A_TOS, d); chk("R7 disabled hold", d, t0);
    rd({2'b01, 6'(t0 + 1)}, d); chk("R7 slot untouched", d, 0);
    wr(A_CTRL, 1);
  endtask

  task automatic t_freeze;
    logic [63:0] d;
    logic [63:0] t0;
    wr(A_CTRL, 3);
    rd(A_TOS, t0);
    @(negedge clk);
    br_valid = 1; br_from = 64'h900; br_to = 64'h980; br_kind = 3'd0; br_ring0 = 0;
    freeze_irq = 1;
    @(negedge clk);
    br_valid = 0; freeze_irq = 0;
    rd(A_CTRL, d); chk("R8 frozen flag", d, 7);
    rd(A_TOS, d);  chk("R8 same cycle kept", d, (t0 + 1) & 15);
    br(64'h990, 64'h9A0, 0, 3'd0, 0, 0, 0);
    rd(A_TOS, d);  chk("R8 frozen ignores", d, (t0 + 1) & 15);
    wr(A_CTRL, 3);
    br(64'h9B0, 64'h9C0, 0, 3'd0, 0, 0, 0);
    rd(A_TOS, d);  chk("R8 unfrozen", d, (t0 + 2) & 15);
    wr(A_CTRL, 1);
    @(negedge clk); freeze_irq = 1;
    @(negedge clk); freeze_irq = 0;
    rd(A_CTRL, d); chk("R8 unarmed irq", d, 1);
  endtask

  task automatic t_collide;
    logic [63:0] d;
    logic [63:0] t0;
    rd(A_TOS, t0);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = A_SEL; reg_wdata = 0;
    br_valid = 1; br_from = 64'hE00; br_to = 64'hE80; br_kind = 3'd0;
    @(negedge clk);
    reg_req = 0; reg_we = 0; br_valid = 0;
    rd(A_TOS, d); chk("R11 dropped", d, t0);
  endtask

  task automatic t_clear;
    logic [63:0] d;
    logic [63:0] t0;
    logic [63:0] acc;
    br(64'hF00, 64'hF80, 0, 3'd0, 0, 0, 0);
    rd(A_TOS, t0);
    wr(A_CLR, 0);
    acc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h40 + 8'(i), d); acc |= d;
      rd(8'h80 + 8'(i), d); acc |= d;
    end
    chk("R9 slots cleared", acc, 0);
    rd(A_TOS, d); chk("R9 tos kept", d, t0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_capture();
    t_priv();
    t_selmask();
    t_kind();
    t_callstack();
    t_enable();
    t_freeze();
    t_collide();
    t_clear();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule